// File: doc/BRIEF.md
# Masked-Write GPIO Pin Controller

This block owns a bank of general-purpose pins, 128 by default, and decides cycle by cycle who drives each pad. A two-level owner select routes each pin to one of three sources: an external peripheral multiplexer, an IO-processor, or the block's own GPIO logic. In GPIO mode the block applies a per-pin output enable, an output value, an output inversion and an open-drain option. Every pad input passes through a two-flop synchronizer. It is then inverted per pin and can be read back.

Software reaches the block over a simple word-addressed register bus. Bits [7:4] of the address select a bank and bits [3:0] select a word inside it. The six GPIO control banks use a write-protect scheme. Each 32-bit write carries 16 control bits in its low half and a per-bit enable in its high half, so one pin can be changed without a read-modify-write. The owner-type bank is a plain read/write bank with 32 pins per word. The input bank is read-only.

Top module: `pinbank_ctrl`

## Requirements
- R1: After reset every control bit is 0. Every pin then follows `mux_out`/`mux_oe`, and every control register reads back 0.
- R2: In a write to a masked bank, control bit n (0..15) takes wdata bit n only when wdata bit n+16 is 1. Otherwise it keeps its value.
- R3: Bank codes in address bits [7:4] are: 0 owner type, 1 GPIO/IO-processor select, 2 output enable, 3 output value, 4 input invert, 5 output invert, 6 open drain, 7 input. In masked banks, pin p sits at word index p/16, bit p%16.
- R4: A read of a masked bank returns bits [31:16] as 0 and bits [15:0] as the stored control bits.
- R5: The owner-type bank stores all 32 bits of a write unmasked, at word index 0..3. Pin p sits at word p/32, bit p%32, and the word reads back as written.
- R6: A type bit of 0 routes the pin to `mux_out`/`mux_oe`. With a type bit of 1, a select bit of 0 routes it to `iop_out`/`iop_oe` and a select bit of 1 gives it to GPIO.
- R7: A GPIO pin without open drain drives `pad_oe` = output-enable bit and `pad_out` = output-value XOR output-invert.
- R8: A GPIO pin with open drain drives `pad_out` = 0 and `pad_oe` = output-enable AND NOT (output-value XOR output-invert).
- R9: Input word w (0..3) bit b reads as the synchronized `pad_in[32w+b]` XOR its input-invert bit. A pad change made just after clock edge k shows in a read captured at edge k+3, and not in one captured at edge k+2.
- R10: `bus_rvalid` rises for exactly one cycle, on the edge after a cycle with `bus_rd`, and `bus_rdata` holds the addressed word. Unused addresses (banks 8..15, owner-type index above 3, masked index above 7) read as 0.
- R11: Writes to the input bank or to unused addresses change no stored bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Word address: bank [7:4], index [3:0] |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| pad_in | input | 128 | Pad input levels, asynchronous |
| pad_out | output | 128 | Pad output value |
| pad_oe | output | 128 | Pad output enable |
| mux_out | input | 128 | Peripheral multiplexer output value |
| mux_oe | input | 128 | Peripheral multiplexer output enable |
| iop_out | input | 128 | IO-processor output value |
| iop_oe | input | 128 | IO-processor output enable |

## Verification
A control bit that is stored in the wrong word or the wrong position, or that a masked write disturbs, changes `pad_oe` or `pad_out` combinationally. It therefore shows on the pads in the cycle right after the write that caused it. For that reason the bench compares all pads against a model after every single write. A fault in the input path shows only through a read, so the read is placed at the exact synchronizer edge. That makes a missing or extra flop visible as an old or early value.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned IDX_W  = 4;
  localparam int unsigned N_MASKED = 6;

  typedef enum logic [3:0] {
    BK_TYPE = 4'd0,
    BK_OWN  = 4'd1,
    BK_OE   = 4'd2,
    BK_DOUT = 4'd3,
    BK_IINV = 4'd4,
    BK_OINV = 4'd5,
    BK_ODRN = 4'd6,
    BK_PIN  = 4'd7
  } bank_e;

  typedef enum logic [1:0] {
    OWN_MUX  = 2'd0,
    OWN_IOP  = 2'd1,
    OWN_GPIO = 2'd2
  } owner_e;

  typedef struct packed {
    logic oe;
    logic val;
  } drive_t;

  // Control bits enabled by the upper half take the new value.
  function automatic logic [HALF_W-1:0] masked_merge(input logic [HALF_W-1:0] cur,
                                                     input logic [REG_W-1:0]  wd);
    logic [HALF_W-1:0] en;
    en = wd[REG_W-1:HALF_W];
    return (cur & ~en) | (wd[HALF_W-1:0] & en);
  endfunction

  function automatic owner_e pin_owner(input logic ty, input logic gsel);
    if (!ty) return OWN_MUX;
    return gsel ? OWN_GPIO : OWN_IOP;
  endfunction

  function automatic drive_t gpio_drive(input logic oe, input logic dout,
                                        input logic oinv, input logic od);
    drive_t d;
    logic   lvl;
    lvl = dout ^ oinv;
    if (od) begin
      d.oe  = oe & ~lvl;
      d.val = 1'b0;
    end else begin
      d.oe  = oe;
      d.val = lvl;
    end
    return d;
  endfunction
endpackage

// File: rtl/pinbank_mask_bank.sv
module pinbank_mask_bank
  import pinbank_pkg::*;
#(
  parameter int unsigned WORDS = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [REG_W-1:0]             wr_data,
  output logic [WORDS-1:0][HALF_W-1:0] bits_q
);
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic              hit;
    logic [HALF_W-1:0] word_q;
    assign hit = wr_en && (int'(wr_idx) == w);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_q <= '0;
      else if (hit) word_q <= masked_merge(word_q, wr_data);
    end
    assign bits_q[w] = word_q;
  end
endmodule

// File: rtl/pinbank_plain_bank.sv
module pinbank_plain_bank
  import pinbank_pkg::*;
#(
  parameter int unsigned WORDS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [REG_W-1:0]            wr_data,
  output logic [WORDS-1:0][REG_W-1:0] bits_q
);
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic             hit;
    logic [REG_W-1:0] word_q;
    assign hit = wr_en && (int'(wr_idx) == w);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_q <= '0;
      else if (hit) word_q <= wr_data;
    end
    assign bits_q[w] = word_q;
  end
endmodule

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
  parameter int unsigned N = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stage1_q;
  logic [N-1:0] stage2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end
  assign q = stage2_q;
endmodule

// File: rtl/pinbank_pad_mux.sv
module pinbank_pad_mux
  import pinbank_pkg::*;
#(
  parameter int unsigned N = 128
) (
  input  logic [N-1:0] ty_v,
  input  logic [N-1:0] own_v,
  input  logic [N-1:0] oe_v,
  input  logic [N-1:0] dout_v,
  input  logic [N-1:0] oinv_v,
  input  logic [N-1:0] od_v,
  input  logic [N-1:0] mux_out,
  input  logic [N-1:0] mux_oe,
  input  logic [N-1:0] iop_out,
  input  logic [N-1:0] iop_oe,
  output logic [N-1:0] pad_out,
  output logic [N-1:0] pad_oe
);
  for (genvar p = 0; p < N; p++) begin : g_pin
    owner_e who;
    drive_t gd;
    assign who = pin_owner(ty_v[p], own_v[p]);
    assign gd  = gpio_drive(oe_v[p], dout_v[p], oinv_v[p], od_v[p]);
    always_comb begin
      unique case (who)
        OWN_GPIO: begin pad_oe[p] = gd.oe;     pad_out[p] = gd.val;     end
        OWN_IOP:  begin pad_oe[p] = iop_oe[p]; pad_out[p] = iop_out[p]; end
        default:  begin pad_oe[p] = mux_oe[p]; pad_out[p] = mux_out[p]; end
      endcase
    end
  end
endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
  import pinbank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 128,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [REG_W-1:0]    bus_wdata,
  input  logic                bus_wr,
  input  logic                bus_rd,
  output logic [REG_W-1:0]    bus_rdata,
  output logic                bus_rvalid,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  input  logic [NUM_PINS-1:0] mux_out,
  input  logic [NUM_PINS-1:0] mux_oe,
  input  logic [NUM_PINS-1:0] iop_out,
  input  logic [NUM_PINS-1:0] iop_oe
);
  localparam int unsigned MW    = NUM_PINS / HALF_W;
  localparam int unsigned PW    = NUM_PINS / REG_W;
  localparam int unsigned BK_W  = ADDR_W - IDX_W;
  localparam int unsigned MW_IW = (MW > 1) ? $clog2(MW) : 1;
  localparam int unsigned PW_IW = (PW > 1) ? $clog2(PW) : 1;

  logic [BK_W-1:0]  a_bank;
  logic [IDX_W-1:0] a_idx;
  assign a_bank = bus_addr[ADDR_W-1:IDX_W];
  assign a_idx  = bus_addr[IDX_W-1:0];

  // Masked banks, slot s holds bank code s+1.
  logic [N_MASKED-1:0][MW-1:0][HALF_W-1:0] mq;
  for (genvar s = 0; s < N_MASKED; s++) begin : g_mbank
    logic sel_wr;
    assign sel_wr = bus_wr && (int'(a_bank) == s + 1);
    pinbank_mask_bank #(.WORDS(MW)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(sel_wr), .wr_idx(a_idx),
      .wr_data(bus_wdata), .bits_q(mq[s])
    );
  end

  logic                       ty_wr;
  logic [PW-1:0][REG_W-1:0]   ty_q;
  assign ty_wr = bus_wr && (a_bank == BK_W'(BK_TYPE));
  pinbank_plain_bank #(.WORDS(PW)) u_type (
    .clk(clk), .rst_n(rst_n), .wr_en(ty_wr), .wr_idx(a_idx),
    .wr_data(bus_wdata), .bits_q(ty_q)
  );

  // Flat per-pin views, named for the checker.
  logic [NUM_PINS-1:0] ty_v, own_v, oe_v, dout_v, iinv_v, oinv_v, od_v;
  assign ty_v   = ty_q;
  assign own_v  = mq[int'(BK_OWN)  - 1];
  assign oe_v   = mq[int'(BK_OE)   - 1];
  assign dout_v = mq[int'(BK_DOUT) - 1];
  assign iinv_v = mq[int'(BK_IINV) - 1];
  assign oinv_v = mq[int'(BK_OINV) - 1];
  assign od_v   = mq[int'(BK_ODRN) - 1];

  logic [NUM_PINS-1:0]      in_sync;
  logic [NUM_PINS-1:0]      in_view;
  logic [PW-1:0][REG_W-1:0] in_words;
  pinbank_sync #(.N(NUM_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(in_sync)
  );
  assign in_view  = in_sync ^ iinv_v;
  assign in_words = in_view;

  pinbank_pad_mux #(.N(NUM_PINS)) u_pads (
    .ty_v(ty_v), .own_v(own_v), .oe_v(oe_v), .dout_v(dout_v),
    .oinv_v(oinv_v), .od_v(od_v), .mux_out(mux_out), .mux_oe(mux_oe),
    .iop_out(iop_out), .iop_oe(iop_oe), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // Read path.
  logic [REG_W-1:0] rd_next;
  logic [2:0]       rd_slot;
  assign rd_slot = 3'(int'(a_bank) - 1);
  always_comb begin
    rd_next = '0;
    if (a_bank == BK_W'(BK_TYPE)) begin
      if (int'(a_idx) < PW) rd_next = ty_q[a_idx[PW_IW-1:0]];
    end else if (a_bank == BK_W'(BK_PIN)) begin
      if (int'(a_idx) < PW) rd_next = in_words[a_idx[PW_IW-1:0]];
    end else if (int'(a_bank) >= 1 && int'(a_bank) <= N_MASKED) begin
      if (int'(a_idx) < MW) rd_next = {{HALF_W{1'b0}}, mq[rd_slot][a_idx[MW_IW-1:0]]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_next;
    end
  end
endmodule

// File: rtl/pinbank_ctrl_chk.sv
module pinbank_ctrl_chk #(
  parameter int unsigned N  = 128,
  parameter int unsigned AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic [31:0]   bus_wdata,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic          bus_rvalid,
  input logic [N-1:0]  ty_v,
  input logic [N-1:0]  own_v,
  input logic [N-1:0]  oe_v,
  input logic [N-1:0]  od_v,
  input logic [N-1:0]  pad_out,
  input logic [N-1:0]  pad_oe,
  input logic [N-1:0]  mux_out,
  input logic [N-1:0]  mux_oe
);
  p_rvalid_after_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  p_no_spurious_rvalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);

  p_mask_protects_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(8'h20)) |=>
      (((oe_v[15:0] ^ $past(oe_v[15:0])) & ~$past(bus_wdata[31:16])) == 16'h0));

  p_type_loads_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(8'h00)) |=> (ty_v[31:0] == $past(bus_wdata)));

  p_mux_owner_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ty_v[0] |-> (pad_oe[0] == mux_oe[0] && pad_out[0] == mux_out[0]));

  p_open_drain_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ty_v[0] && own_v[0] && od_v[0]) |-> !pad_out[0]);
endmodule

bind pinbank_ctrl pinbank_ctrl_chk #(.N(NUM_PINS), .AW(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rvalid(bus_rvalid),
  .ty_v(ty_v), .own_v(own_v), .oe_v(oe_v), .od_v(od_v),
  .pad_out(pad_out), .pad_oe(pad_oe), .mux_out(mux_out), .mux_oe(mux_oe)
);

// File: tb/pinbank_ctrl_test.sv
module pinbank_ctrl_test;
  localparam int N = 128;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [31:0]   bus_rdata;
  logic          bus_rvalid;
  logic [N-1:0]  pad_in = '0;
  logic [N-1:0]  pad_out, pad_oe;
  logic [N-1:0]  mux_out = '0, mux_oe = '0, iop_out = '0, iop_oe = '0;

  int n_chk = 0;
  int n_bad = 0;

  // Bench-side model of the stored bits.
  logic [N-1:0] m_ty = '0, m_own = '0, m_oe = '0, m_dout = '0;
  logic [N-1:0] m_iinv = '0, m_oinv = '0, m_od = '0;

  pinbank_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .mux_out(mux_out), .mux_oe(mux_oe), .iop_out(iop_out), .iop_oe(iop_oe)
  );

  always #10 clk = ~clk;

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
    $finish;
  end

  task automatic chk32(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
    chk32("R10", "rvalid", {31'h0, bus_rvalid}, 32'h1);
    d = bus_rdata;
  endtask

  function automatic logic [15:0] mget(input int bank, input int w);
    case (bank)
      1: return m_own[w*16 +: 16];
      2: return m_oe[w*16 +: 16];
      3: return m_dout[w*16 +: 16];
      4: return m_iinv[w*16 +: 16];
      5: return m_oinv[w*16 +: 16];
      default: return m_od[w*16 +: 16];
    endcase
  endfunction

  task automatic mput(input int bank, input int w, input logic [15:0] v);
    case (bank)
      1: m_own[w*16 +: 16] = v;
      2: m_oe[w*16 +: 16] = v;
      3: m_dout[w*16 +: 16] = v;
      4: m_iinv[w*16 +: 16] = v;
      5: m_oinv[w*16 +: 16] = v;
      default: m_od[w*16 +: 16] = v;
    endcase
  endtask

  // Masked single-pin write: word p/16, value bit p%16, enable bit p%16+16 (R3, R2).
  task automatic set_pin(input int bank, input int p, input logic v);
    logic [15:0] t;
    wr({4'(bank), 4'(p / 16)}, (32'h1 << (16 + p % 16)) | (32'(v) << (p % 16)));
    t = mget(bank, p / 16);
    t[p % 16] = v;
    mput(bank, p / 16, t);
  endtask

  task automatic set_type(input int p, input logic v);
    m_ty[p] = v;
    wr({4'h0, 4'(p / 32)}, m_ty[(p / 32) * 32 +: 32]);
  endtask

  task automatic check_pads(input string req);
    logic [N-1:0] eo, ev;
    for (int p = 0; p < N; p++) begin
      if (!m_ty[p]) begin
        eo[p] = mux_oe[p]; ev[p] = mux_out[p];
      end else if (!m_own[p]) begin
        eo[p] = iop_oe[p]; ev[p] = iop_out[p];
      end else if (m_od[p]) begin
        ev[p] = 1'b0;
        eo[p] = m_oe[p] && (m_dout[p] == m_oinv[p]);
      end else begin
        eo[p] = m_oe[p];
        ev[p] = (m_dout[p] != m_oinv[p]);
      end
    end
    n_chk++;
    if (pad_oe !== eo || pad_out !== ev) begin
      n_bad++;
      $display("FAIL %s pads: got oe=%h out=%h expected oe=%h out=%h",
               req, pad_oe, pad_out, eo, ev);
    end
  endtask

  function automatic logic [31:0] exp_in(input int w);
    logic [N-1:0] v;
    v = pad_in ^ m_iinv;
    return v[w*32 +: 32];
  endfunction

  initial begin
    logic [31:0] d;
    logic [15:0] a16, m16, b16, e16;
    mux_out = {4{32'h6B2D_9C41}};
    mux_oe  = {4{32'hC3A5_0F96}};
    iop_out = {4{32'h1E87_D24B}};
    iop_oe  = {4{32'h5A3C_E1B7}};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset values on every register and pad routing.
    for (int b = 0; b < 8; b++)
      for (int w = 0; w < ((b == 0 || b == 7) ? 4 : 8); w++) begin
        rd({4'(b), 4'(w)}, d);
        chk32("R1", $sformatf("reset bank %0d word %0d", b, w), d, 32'h0);
      end
    check_pads("R1");

    // R2/R4: masked writes on every word of every masked bank.
    for (int b = 1; b <= 6; b++)
      for (int w = 0; w < 8; w++) begin
        a16 = 16'(w * 16'h1357) ^ 16'(b * 16'h2468) ^ 16'h9E31;
        m16 = 16'hF00F ^ 16'(w * 16'h0111) ^ 16'(b << 5);
        b16 = ~a16 ^ 16'(b * 16'h0505);
        wr({4'(b), 4'(w)}, {16'hFFFF, a16});
        mput(b, w, a16);
        wr({4'(b), 4'(w)}, {m16, b16});
        e16 = (a16 & ~m16) | (b16 & m16);
        mput(b, w, e16);
        rd({4'(b), 4'(w)}, d);
        chk32("R2 R4", $sformatf("masked bank %0d word %0d", b, w), d, {16'h0, e16});
        wr({4'(b), 4'(w)}, {16'h0000, ~e16});
        rd({4'(b), 4'(w)}, d);
        chk32("R2", $sformatf("zero-mask bank %0d word %0d", b, w), d, {16'h0, e16});
      end
    check_pads("R2");

    // R5: plain owner-type words.
    for (int w = 0; w < 4; w++) begin
      d = 32'hA5F0_3C96 ^ (32'(w) * 32'h1111_0101);
      wr({4'h0, 4'(w)}, d);
      m_ty[w*32 +: 32] = d;
    end
    for (int w = 0; w < 4; w++) begin
      rd({4'h0, 4'(w)}, d);
      chk32("R5", $sformatf("type word %0d", w), d, m_ty[w*32 +: 32]);
    end
    check_pads("R5 R6");

    // Clear everything back to reset values.
    for (int w = 0; w < 4; w++) begin wr({4'h0, 4'(w)}, 32'h0); m_ty[w*32 +: 32] = '0; end
    for (int b = 1; b <= 6; b++)
      for (int w = 0; w < 8; w++) begin wr({4'(b), 4'(w)}, 32'hFFFF_0000); mput(b, w, 16'h0); end
    check_pads("R1");

    // R3/R6/R7/R8: sweep every pin through every owner and GPIO combination.
    for (int p = 0; p < N; p++) begin
      mux_out = {4{32'h6B2D_9C41}} >> (p % 7);
      iop_oe  = {4{32'h5A3C_E1B7}} << (p % 5);
      set_type(p, 1'b0);
      check_pads("R3 R6 mux");
      set_type(p, 1'b1);
      set_pin(1, p, 1'b0);
      check_pads("R3 R6 iop");
      set_pin(1, p, 1'b1);
      for (int c = 0; c < 16; c++) begin
        set_pin(2, p, c[0]);
        set_pin(3, p, c[1]);
        set_pin(5, p, c[2]);
        set_pin(6, p, c[3]);
        check_pads(c[3] ? "R3 R8 open-drain" : "R3 R7 push-pull");
      end
    end

    // R9: input inversion and synchronizer latency.
    for (int w = 0; w < 8; w++) begin
      a16 = 16'h3C5A ^ 16'(w * 16'h1F07);
      wr({4'h4, 4'(w)}, {16'hFFFF, a16});
      mput(4, w, a16);
    end
    pad_in = {4{32'h0F0F_33CC}};
    repeat (3) @(negedge clk);
    rd(8'h70, d);
    chk32("R9", "settled input word 0", d, exp_in(0));
    e16 = 16'h0;
    begin
      logic [31:0] old0;
      old0 = exp_in(0);
      pad_in = ~pad_in;
      rd(8'h70, d);
      chk32("R9", "edge k+1 read", d, old0);
      rd(8'h70, d);
      chk32("R9", "edge k+2 read", d, old0);
      rd(8'h70, d);
      chk32("R9", "edge k+3 read", d, exp_in(0));
    end
    for (int k = 0; k < 3; k++) begin
      pad_in = {32'h8124_7E11, 32'hDEAD_0BE3, 32'h1357_9BDF, 32'h0246_8ACE} ^ (128'(k) * 128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0);
      repeat (3) @(negedge clk);
      for (int w = 0; w < 4; w++) begin
        rd({4'h7, 4'(w)}, d);
        chk32("R9", $sformatf("input pattern %0d word %0d", k, w), d, exp_in(w));
      end
    end

    // R10/R11: writes to read-only and unused addresses are ignored.
    wr(8'h70, 32'hFFFF_FFFF);
    wr(8'h73, 32'hFFFF_FFFF);
    wr(8'h80, 32'hFFFF_FFFF);
    wr(8'hF5, 32'hFFFF_FFFF);
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h2F, 32'hFFFF_FFFF);
    wr(8'h04, 32'hFFFF_FFFF);
    for (int w = 0; w < 4; w++) begin
      rd({4'h7, 4'(w)}, d);
      chk32("R11", $sformatf("input word %0d after write", w), d, exp_in(w));
      rd({4'h0, 4'(w)}, d);
      chk32("R11", $sformatf("type word %0d untouched", w), d, m_ty[w*32 +: 32]);
    end
    for (int w = 0; w < 8; w++) begin
      rd({4'h1, 4'(w)}, d);
      chk32("R11", $sformatf("select word %0d untouched", w), d, {16'h0, m_own[w*16 +: 16]});
      rd({4'h2, 4'(w)}, d);
      chk32("R11", $sformatf("oe word %0d untouched", w), d, {16'h0, m_oe[w*16 +: 16]});
    end
    check_pads("R11");
    rd(8'h80, d);  chk32("R10", "unused bank 8", d, 32'h0);
    rd(8'hF5, d);  chk32("R10", "unused bank 15", d, 32'h0);
    rd(8'h18, d);  chk32("R10", "select index 8", d, 32'h0);
    rd(8'h04, d);  chk32("R10", "type index 4", d, 32'h0);
    rd(8'h74, d);  chk32("R10", "input index 4", d, 32'h0);
    @(negedge clk);
    chk32("R10", "rvalid single cycle", {31'h0, bus_rvalid}, 32'h0);

    report();
    $finish;
  end
endmodule